// File: doc/BRIEF.md
# Adaptive Body-Bias Calibration Sequencer

This block runs once after power-on and picks a body-bias setting for each submodule of a die, one submodule at a time. The bias for each submodule is a signed step code. Negative codes mean reverse bias, which lowers leakage and slows the logic. Positive codes mean forward bias, which speeds the logic up. A code of zero means no bias. For the submodule under calibration, the sequencer applies each trial code in turn. It waits a programmable number of cycles so that the analog bias can settle. It then drives a short built-in vector sequence into the submodule through the test port and compares every returned word with the word the healthy logic must produce at the target clock rate.

The search starts at the strongest reverse code and moves one step toward forward bias after each failing trial. The first code that passes is kept, because it is the passing setting with the least leakage. If no code passes, the submodule's fail flag is set and the strongest forward code stays applied. When every submodule has been handled, the done output rises, and all codes stay frozen until the next reset. The analog bias generators are driven from the code bus only.

Top module: `bias_cal_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `done_o` is 0, `fail_o` is all zeros, `tst_valid_o` is 0 and every code field of `bias_code_o` is 0 (zero bias).
- R2: A calibration run begins only on `start_i` while idle. `start_i` has no effect during a run or after `done_o` has risen: no vector strobe appears and no code or flag changes.
- R3: The submodules are calibrated in index order, from 0 up to N_MOD-1. For each submodule the trial codes are -MAX_STEP, -MAX_STEP+1, and so on upward by one. Each code is a CODE_W-bit two's-complement field, and submodule m occupies bits [m*CODE_W +: CODE_W] of `bias_code_o`. Submodules not yet reached read 0.
- R4: After each change of the code bus, the first vector strobe of the new trial appears exactly settle_i+1 clock cycles later. The code bus does not change while a strobe is high.
- R5: For each trial, N_VEC strobes are issued with vector indices 0 to N_VEC-1, one every two cycles. Each strobe carries the stimulus (v*53) XOR 167, truncated to DATA_W bits. The response is sampled on `tst_resp_i` in the cycle after the strobe. The expected response is the stimulus rotated left by one bit.
- R6: If even one response word mismatches, that trial code fails. The first code whose N_VEC responses all match is kept for that submodule, and the run moves on to the next submodule.
- R7: If the +MAX_STEP trial also fails, the submodule's bit in `fail_o` is set and its code stays at +MAX_STEP.
- R8: `done_o` rises only after the last submodule has been decided. From then on, `done_o`, `bias_code_o` and `fail_o` hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin calibration (accepted once, while idle) |
| settle_i | input | SETTLE_W | Settle wait, in cycles, after each code change (actual wait is settle_i+1) |
| tst_valid_o | output | 1 | Test vector strobe |
| tst_mod_o | output | $clog2(N_MOD) | Index of the submodule under test |
| tst_vec_o | output | $clog2(N_VEC) | Index of the current vector |
| tst_stim_o | output | DATA_W | Stimulus word |
| tst_resp_i | input | DATA_W | Response word, valid the cycle after the strobe |
| bias_code_o | output | N_MOD*CODE_W | Signed bias code per submodule |
| fail_o | output | N_MOD | Per-submodule flag: no code passed |
| done_o | output | 1 | Calibration complete |

## Verification
The bench models each submodule as having a pass threshold on its code. Below that threshold, exactly one vector, chosen per submodule, returns a corrupted word. This tells apart a compare that checks every word from one that checks only some of them. The first sweep spreads the thresholds across the whole range, including one below the lowest code (pass on the first trial), one exactly at it, and one above the highest code (fail). It also pulses start in the middle of the run. A second sweep uses a zero settle time and alternates thresholds between +MAX_STEP (pass on the last trial) and just beyond it (fail). This separates the last-code pass case from the fail case. A third sweep passes every submodule on its first trial with a longer settle time. Throughout each sweep the bench checks the order of trials, the settle gap, the stimulus words and the final codes and flags against arithmetic it computes itself.

// File: rtl/bias_cal_pkg.sv
package bias_cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_DRIVE,
        ST_CHECK,
        ST_DONE
    } cal_st_e;
endpackage

// File: rtl/cal_vecgen.sv
module cal_vecgen #(
    parameter int DATA_W   = 8,
    parameter int VEC_W    = 2,
    parameter int STIM_MUL = 53,
    parameter int STIM_XOR = 167
) (
    input  logic [VEC_W-1:0]  vec_i,
    output logic [DATA_W-1:0] stim_o,
    output logic [DATA_W-1:0] exp_o
);
    logic [31:0] prod;
    logic [31:0] mask_xor;

    always_comb begin
        prod     = 32'(vec_i) * 32'(STIM_MUL);
        mask_xor = 32'(STIM_XOR);
        stim_o   = prod[DATA_W-1:0] ^ mask_xor[DATA_W-1:0];
        exp_o    = {stim_o[DATA_W-2:0], stim_o[DATA_W-1]};
    end
endmodule

// File: rtl/cal_settle_tmr.sv
module cal_settle_tmr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             exp_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld_i)
            cnt_d = '0;
        else if (cnt_q != lim_i)
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign exp_o = (cnt_q == lim_i) && !ld_i;

    // R4: a load always restarts the wait from zero
    p_ld_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_q == '0));
endmodule

// File: rtl/bias_cal_ctrl.sv
module bias_cal_ctrl #(
    parameter int N_MOD    = 21,
    parameter int MAX_STEP = 15,
    parameter int N_VEC    = 4,
    parameter int DATA_W   = 8,
    parameter int SETTLE_W = 8
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           start_i,
    input  logic [SETTLE_W-1:0]                            settle_i,
    output logic                                           tst_valid_o,
    output logic [$clog2(N_MOD)-1:0]                       tst_mod_o,
    output logic [$clog2(N_VEC)-1:0]                       tst_vec_o,
    output logic [DATA_W-1:0]                              tst_stim_o,
    input  logic [DATA_W-1:0]                              tst_resp_i,
    output logic [N_MOD*($clog2(MAX_STEP+1)+1)-1:0]        bias_code_o,
    output logic [N_MOD-1:0]                               fail_o,
    output logic                                           done_o
);
    import bias_cal_pkg::*;

    localparam int MOD_W  = $clog2(N_MOD);
    localparam int VEC_W  = $clog2(N_VEC);
    localparam int CODE_W = $clog2(MAX_STEP+1) + 1;
    localparam int LO_I   = -MAX_STEP;
    localparam int HI_I   = MAX_STEP;
    localparam logic [CODE_W-1:0] CODE_LO  = LO_I[CODE_W-1:0];
    localparam logic [CODE_W-1:0] CODE_HI  = HI_I[CODE_W-1:0];
    localparam logic [VEC_W-1:0]  VEC_LAST = VEC_W'(N_VEC-1);
    localparam logic [MOD_W-1:0]  MOD_LAST = MOD_W'(N_MOD-1);

    typedef struct packed {
        cal_st_e                        st;
        logic [MOD_W-1:0]               mod;
        logic [CODE_W-1:0]              code;
        logic [VEC_W-1:0]               vec;
        logic                           mis;
        logic [N_MOD-1:0][CODE_W-1:0]   codes;
        logic [N_MOD-1:0]               fail;
        logic                           done;
    } cal_state_t;

    cal_state_t r_d, r_q;
    logic              tmr_ld, tmr_exp;
    logic [DATA_W-1:0] exp_word;
    logic              miss_now, trial_ok, advance;
    logic [MOD_W-1:0]  nxt_mod;

    cal_vecgen #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_vecgen (
        .vec_i  (r_q.vec),
        .stim_o (tst_stim_o),
        .exp_o  (exp_word)
    );

    cal_settle_tmr #(.CNT_W(SETTLE_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_i  (tmr_ld),
        .lim_i (settle_i),
        .exp_o (tmr_exp)
    );

    always_comb begin
        r_d      = r_q;
        tmr_ld   = 1'b0;
        advance  = 1'b0;
        miss_now = (tst_resp_i != exp_word);
        trial_ok = !(r_q.mis || miss_now);
        nxt_mod  = r_q.mod + MOD_W'(1);

        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.mod      = '0;
                    r_d.code     = CODE_LO;
                    r_d.codes[0] = CODE_LO;
                    r_d.st       = ST_SETTLE;
                    tmr_ld       = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) begin
                    r_d.vec = '0;
                    r_d.mis = 1'b0;
                    r_d.st  = ST_DRIVE;
                end
            end
            ST_DRIVE: r_d.st = ST_CHECK;
            ST_CHECK: begin
                if (r_q.vec != VEC_LAST) begin
                    r_d.mis = r_q.mis || miss_now;
                    r_d.vec = r_q.vec + VEC_W'(1);
                    r_d.st  = ST_DRIVE;
                end else if (trial_ok) begin
                    advance = 1'b1;
                end else if (r_q.code == CODE_HI) begin
                    r_d.fail[r_q.mod] = 1'b1;
                    advance           = 1'b1;
                end else begin
                    r_d.code             = r_q.code + CODE_W'(1);
                    r_d.codes[r_q.mod]   = r_q.code + CODE_W'(1);
                    r_d.st               = ST_SETTLE;
                    tmr_ld               = 1'b1;
                end
            end
            ST_DONE: r_d.done = 1'b1;
            default: r_d.st = ST_IDLE;
        endcase

        if (advance) begin
            if (r_q.mod == MOD_LAST) begin
                r_d.st   = ST_DONE;
                r_d.done = 1'b1;
            end else begin
                r_d.mod            = nxt_mod;
                r_d.code           = CODE_LO;
                r_d.codes[nxt_mod] = CODE_LO;
                r_d.st             = ST_SETTLE;
                tmr_ld             = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign tst_valid_o = (r_q.st == ST_DRIVE);
    assign tst_mod_o   = r_q.mod;
    assign tst_vec_o   = r_q.vec;
    assign bias_code_o = r_q.codes;
    assign fail_o      = r_q.fail;
    assign done_o      = r_q.done;

    // R3: the trial code never leaves the signed step range
    always_ff @(posedge clk) begin
        if (rst_n) begin
            p_code_range_r3: assert ($signed(r_q.code) >= $signed(CODE_LO)
                                     && $signed(r_q.code) <= $signed(CODE_HI));
        end
    end

    // R4: code bus is steady while a vector is applied
    p_code_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tst_valid_o |-> $stable(bias_code_o));

    // R2: no strobes once calibration is complete
    p_quiet_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !tst_valid_o);

    // R8: completion and results are frozen
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o && $stable(bias_code_o) && $stable(fail_o));

    // R7: a failed submodule sits at the strongest forward code
    for (genvar m = 0; m < N_MOD; m++) begin : g_fail_chk
        p_fail_at_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
            fail_o[m] |-> (bias_code_o[m*CODE_W +: CODE_W] == CODE_HI));
    end
endmodule

// File: tb/sim_bias_cal_ctrl.sv
module sim_bias_cal_ctrl;
    localparam int NM = 21;
    localparam int CW = 5;
    localparam int NV = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [7:0]         settle_i = 8'd0;
    logic               tst_valid_o;
    logic [4:0]         tst_mod_o;
    logic [1:0]         tst_vec_o;
    logic [7:0]         tst_stim_o;
    logic [7:0]         tst_resp_i = 8'd0;
    logic [NM*CW-1:0]   bias_code_o;
    logic [NM-1:0]      fail_o;
    logic               done_o;

    int checks = 0;
    int errors = 0;
    int thr [NM];

    bias_cal_ctrl u0 (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] stimf(input int v);
        return 8'(v * 53) ^ 8'd167;
    endfunction

    function automatic logic [7:0] expf(input int v);
        logic [7:0] s;
        s = stimf(v);
        return {s[6:0], s[7]};
    endfunction

    function automatic int code_of(input logic [NM*CW-1:0] bus, input int m);
        logic signed [CW-1:0] c;
        c = bus[m*CW +: CW];
        return int'(c);
    endfunction

    // submodule model: below threshold one vector per module returns a bad word
    always @(posedge clk) begin
        if (tst_valid_o) begin
            if (code_of(bias_code_o, int'(tst_mod_o)) < thr[tst_mod_o]
                && int'(tst_vec_o) == int'(tst_mod_o) % NV)
                tst_resp_i <= expf(int'(tst_vec_o)) ^ 8'h10;
            else
                tst_resp_i <= expf(int'(tst_vec_o));
        end
    end

    // monitor
    logic [NM*CW-1:0] last_bus;
    int  gap, pm, pc, strobes, trials;
    bit  seen, done_seen, valid_after_done;

    always @(negedge clk) begin
        if (!rst_n) begin
            last_bus = bias_code_o;
            gap = 0; seen = 0; done_seen = 0; valid_after_done = 0;
            strobes = 0; trials = 0; pm = 0; pc = 0;
        end else begin
            if (bias_code_o != last_bus) gap = 0;
            else gap++;
            last_bus = bias_code_o;
            if (tst_valid_o) begin
                if (done_seen) valid_after_done = 1;
                chk(tst_stim_o == stimf(int'(tst_vec_o)), "R5", "stimulus word",
                    int'(tst_stim_o), int'(stimf(int'(tst_vec_o))));
                if (tst_vec_o == 2'd0) begin
                    int em, ec;
                    if (!seen) begin em = 0; ec = -15; end
                    else if (pc >= thr[pm] || pc == 15) begin em = pm + 1; ec = -15; end
                    else begin em = pm; ec = pc + 1; end
                    if (seen)
                        chk(strobes == NV, "R5", "strobes per trial", strobes, NV);
                    chk(int'(tst_mod_o) == em, "R3", "trial module", int'(tst_mod_o), em);
                    chk(code_of(bias_code_o, em) == ec, "R3", "trial code",
                        code_of(bias_code_o, em), ec);
                    chk(gap == int'(settle_i) + 1, "R4", "settle gap", gap, int'(settle_i) + 1);
                    pm = em; pc = ec; seen = 1; strobes = 0; trials++;
                end
                chk(int'(tst_vec_o) == strobes, "R5", "vector index", int'(tst_vec_o), strobes);
                strobes++;
            end
            if (done_o && !done_seen) begin
                done_seen = 1;
                chk(pm == NM - 1 && strobes == NV && (pc >= thr[pm] || pc == 15),
                    "R8", "done after last module", pm, NM - 1);
            end
        end
    end

    task automatic run_scn(input int sc, input int settle, input bit mid_start);
        logic [NM*CW-1:0] bus_snap;
        logic [NM-1:0]    fail_snap;
        for (int m = 0; m < NM; m++) begin
            if (sc == 0)      thr[m] = (m * 7) % 33 - 16;
            else if (sc == 1) thr[m] = (m % 2 == 0) ? 15 : 16;
            else              thr[m] = -20;
        end
        settle_i = 8'(settle);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0 && tst_valid_o == 1'b0, "R1", "reset done/valid",
            int'(done_o), 0);
        chk(fail_o == '0 && bias_code_o == '0, "R1", "reset codes/flags",
            int'(fail_o != '0), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(tst_valid_o == 1'b0 && bias_code_o == '0, "R2", "idle without start",
            int'(tst_valid_o), 0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (mid_start) begin
            repeat (300) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        for (int m = 0; m < NM; m++) begin
            int ec;
            bit ef;
            ef = thr[m] > 15;
            ec = (thr[m] <= -15) ? -15 : (ef ? 15 : thr[m]);
            chk(code_of(bias_code_o, m) == ec, ef ? "R7" : "R6", "final code",
                code_of(bias_code_o, m), ec);
            chk(fail_o[m] == ef, "R7", "fail flag", int'(fail_o[m]), int'(ef));
        end
        bus_snap  = bias_code_o;
        fail_snap = fail_o;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        chk(bias_code_o == bus_snap && fail_o == fail_snap, "R8", "results hold",
            int'(bias_code_o != bus_snap), 0);
        chk(!valid_after_done && done_o, "R2", "start ignored after done",
            int'(valid_after_done), 0);
    endtask

    initial begin
        run_scn(0, 2, 1'b1);
        run_scn(1, 0, 1'b0);
        run_scn(2, 5, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog: done_o act=%0d exp=1", int'(done_o));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule